// File: doc/BRIEF.md
# Request/Grant Bus Handoff Arbiter

This block sits beside a processor's bus-cycle sequencer and lends the local bus to other masters. Each borrowing master owns one shared active-low wire, which is modelled here as a line input, a line output and an output enable. On that wire the master asks for the bus with a one-clock low pulse. This block answers with a one-clock low grant pulse and then reports hold-acknowledge. The master gives the bus back with a final one-clock low pulse. Each handoff therefore takes three pulses on one wire.

The sequencer supplies the current T-state. It also supplies three qualifiers for the cycle in progress: a locked instruction is running, the cycle is the first interrupt-acknowledge, and the cycle is the low-byte half of a word split across an odd address. The arbiter uses these to pick the clock in which the grant may go out. It grants in the idle state or T1 when no lock is held. It grants at the closing T4 of a cycle only when all the cycle conditions allow it. Channel 0 wins over channel 1. After each return of the bus, one clock must pass before any new grant.

Top module: `rqgt_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no request, every line output is high, every output enable is low and hold-acknowledge is low.
- R2: A request is a line input that is low for one clock. A line that stays high, such as an unconnected line with its pull-up, never causes a grant.
- R3: T-state encoding on `tstate_i`: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4. A pending request on an idle or T1 clock with `lock_i` low produces a grant in that same clock. The grant drives the channel's line output low with its output enable high, for exactly one clock, on that channel only.
- R4: In the clock after a grant, `hold_ack_o` is high and `hold_chan_o` gives the granted channel index. Both stay as they are until that channel sends its release pulse.
- R5: A low line input from the holding channel ends the hold, and `hold_ack_o` is low in the next clock.
- R6: In the clock after `hold_ack_o` falls, no grant is issued (dead cycle). A request still pending may be granted one clock later.
- R7: A grant on a T4 clock requires `lock_i`, `inta_first_i` and `odd_low_i` all low. A request seen in T2 or earlier is eligible.
- R8: A request seen during T3 or a wait state is not granted at the T4 that closes that cycle. It stays pending and is granted at the next allowed clock.
- R9: No grant is issued on T2, T3 or wait clocks, nor on any clock while `lock_i` is high. Requests held back this way stay pending.
- R10: When both channels are pending at an allowed clock, channel 0 is granted. Channel 1 stays pending and is served after channel 0's exchange and dead cycle.
- R11: While a channel holds the bus, pulses on lower-priority channels are ignored and are never granted later. A pulse on a higher-priority channel is kept pending. Neither kind of pulse ends the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tstate_i | input | 3 | Current bus T-state (encoding in R3) |
| lock_i | input | 1 | Locked instruction executing |
| inta_first_i | input | 1 | Current cycle is the first interrupt-acknowledge |
| odd_low_i | input | 1 | Current cycle is the low byte of an odd-address word |
| rg_in_n | input | 2 | Line level seen on each request/grant wire, active low |
| rg_out_n | output | 2 | Level driven on each wire, active low |
| rg_oe | output | 2 | Output enable per wire, high only during a grant pulse |
| hold_ack_o | output | 1 | Bus lent to another master |
| hold_chan_o | output | 1 | Index of the channel holding the bus |

## Verification
Two functions can land on the same clock. One is deciding whether a grant may go out at the current T-state, which depends on the lock and cycle qualifiers and on when the request arrived. The other is picking between two channels, or serving a pending request right after the dead cycle that follows a release. The bench sweeps every T-state at the grant clock against every combination of the three qualifiers and of early versus late request timing. In each case it computes from R3, R7, R8 and R9 whether the grant must appear at once or only at the next idle clock. Directed sequences then make both channels pulse in the same clock, and make pulses arrive during a hold. These check that the winner, the dead cycle and the order of later service match the priority rules.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  typedef enum logic [1:0] {
    ARB_OWN  = 2'd0,
    ARB_HOLD = 2'd1,
    ARB_DEAD = 2'd2
  } arb_e;
endpackage

// File: rtl/rqgt_req_capture.sv
// Per-channel pending request and "arrived late in the cycle" flags.
module rqgt_req_capture #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_seen,
  input  logic [NCH-1:0] clr,
  input  logic           in_late_phase,
  input  logic           cyc_end,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] late
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic pend_d, late_d;

    always_comb begin
      pend_d = pend[c];
      late_d = late[c];
      if (clr[c]) begin
        pend_d = 1'b0;
        late_d = 1'b0;
      end else if (req_seen[c] && !pend[c]) begin
        pend_d = 1'b1;
        late_d = in_late_phase;
      end else if (cyc_end) begin
        late_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[c] <= 1'b0;
        late[c] <= 1'b0;
      end else begin
        pend[c] <= pend_d;
        late[c] <= late_d;
      end
    end
  end
endmodule

// File: rtl/rqgt_prio_pick.sv
// Fixed priority: lowest index wins.
module rqgt_prio_pick #(
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input  logic [NCH-1:0] elig,
  output logic [NCH-1:0] pick,
  output logic [CW-1:0]  pick_idx
);
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i] && (pick == '0)) begin
        pick[i]  = 1'b1;
        pick_idx = CW'(i);
      end
    end
  end
endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     tstate_i,
  input  logic           lock_i,
  input  logic           inta_first_i,
  input  logic           odd_low_i,
  input  logic [NCH-1:0] rg_in_n,
  output logic [NCH-1:0] rg_out_n,
  output logic [NCH-1:0] rg_oe,
  output logic           hold_ack_o,
  output logic [CW-1:0]  hold_chan_o
);
  import rqgt_pkg::*;

  arb_e            state_q, state_d;
  logic [CW-1:0]   hold_chan_q, hold_chan_d;
  logic [NCH-1:0]  pend, late, elig, pick, cap_mask, req_seen, grant_vec;
  logic [CW-1:0]   pick_idx;
  logic            ts_open, ts_end, ts_late;
  logic            allow_open, allow_end, grant_now, rel_now;

  // T-state decode
  assign ts_open = (tstate_i == TS_IDLE) || (tstate_i == TS_T1);
  assign ts_end  = (tstate_i == TS_T4);
  assign ts_late = (tstate_i == TS_T3) || (tstate_i == TS_TW);

  assign allow_open = ts_open && !lock_i;
  assign allow_end  = ts_end && !lock_i && !inta_first_i && !odd_low_i;

  // Which channels may register a request this clock
  for (genvar c = 0; c < NCH; c++) begin : g_mask
    always_comb begin
      if (state_q == ARB_HOLD) cap_mask[c] = (CW'(c) < hold_chan_q);
      else                     cap_mask[c] = 1'b1;
    end
  end
  assign req_seen = ~rg_in_n & cap_mask;

  rqgt_req_capture #(.NCH(NCH)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_seen      (req_seen),
    .clr           (grant_vec),
    .in_late_phase (ts_late),
    .cyc_end       (ts_end),
    .pend          (pend),
    .late          (late)
  );

  assign elig = ts_end ? (pend & ~late) : pend;

  rqgt_prio_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .elig     (elig),
    .pick     (pick),
    .pick_idx (pick_idx)
  );

  assign grant_now = (state_q == ARB_OWN) && (allow_open || allow_end) && (|elig);
  assign grant_vec = grant_now ? pick : '0;
  assign rel_now   = (state_q == ARB_HOLD) && !rg_in_n[hold_chan_q];

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    hold_chan_d = hold_chan_q;
    unique case (state_q)
      ARB_OWN: if (grant_now) begin
        state_d     = ARB_HOLD;
        hold_chan_d = pick_idx;
      end
      ARB_HOLD: if (rel_now) state_d = ARB_DEAD;
      ARB_DEAD: state_d = ARB_OWN;
      default:  state_d = ARB_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ARB_OWN;
      hold_chan_q <= '0;
    end else begin
      state_q     <= state_d;
      hold_chan_q <= hold_chan_d;
    end
  end

  assign rg_oe       = grant_vec;
  assign rg_out_n    = ~grant_vec;
  assign hold_ack_o  = (state_q == ARB_HOLD);
  assign hold_chan_o = hold_chan_q;
endmodule

// File: rtl/rqgt_arbiter_chk.sv
module rqgt_arbiter_chk #(
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     tstate_i,
  input logic           lock_i,
  input logic           inta_first_i,
  input logic           odd_low_i,
  input logic [NCH-1:0] rg_in_n,
  input logic [NCH-1:0] rg_out_n,
  input logic [NCH-1:0] rg_oe,
  input logic           hold_ack_o,
  input logic [CW-1:0]  hold_chan_o
);
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rg_oe) && ((rg_oe & rg_out_n) == '0));

  // R9
  grant_tstate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_oe != '0) |-> (!lock_i && (tstate_i == 3'd0 || tstate_i == 3'd1 || tstate_i == 3'd5)));

  // R7
  grant_t4_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rg_oe != '0) && tstate_i == 3'd5) |-> (!inta_first_i && !odd_low_i));

  // R4
  grant_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_oe != '0) |=> (hold_ack_o && rg_oe == '0));

  // R5
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack_o && !rg_in_n[hold_chan_o]) |=> !hold_ack_o);

  // R6
  dead_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_o) |-> (rg_oe == '0));

  // R4
  hold_chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack_o && $past(hold_ack_o)) |-> $stable(hold_chan_o));
endmodule

bind rqgt_arbiter rqgt_arbiter_chk #(.NCH(NCH), .CW(CW)) u_rqgt_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tstate_i     (tstate_i),
  .lock_i       (lock_i),
  .inta_first_i (inta_first_i),
  .odd_low_i    (odd_low_i),
  .rg_in_n      (rg_in_n),
  .rg_out_n     (rg_out_n),
  .rg_oe        (rg_oe),
  .hold_ack_o   (hold_ack_o),
  .hold_chan_o  (hold_chan_o)
);

// File: tb/test_rqgt_arbiter.sv
module test_rqgt_arbiter;
  logic       clk;
  logic       rst_n;
  logic [2:0] tstate_i;
  logic       lock_i, inta_first_i, odd_low_i;
  logic [1:0] rg_in_n;
  logic [1:0] rg_out_n, rg_oe;
  logic       hold_ack_o;
  logic [0:0] hold_chan_o;

  int checks = 0;
  int errors = 0;

  rqgt_arbiter i_rqgt_arbiter (
    .clk (clk), .rst_n (rst_n), .tstate_i (tstate_i), .lock_i (lock_i),
    .inta_first_i (inta_first_i), .odd_low_i (odd_low_i),
    .rg_in_n (rg_in_n), .rg_out_n (rg_out_n), .rg_oe (rg_oe),
    .hold_ack_o (hold_ack_o), .hold_chan_o (hold_chan_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Drive inputs just after a falling edge; outputs are read 2 ns later.
  task automatic drive(input int ts, input bit lk, input bit ia, input bit od, input logic [1:0] ln);
    tstate_i = 3'(ts); lock_i = lk; inta_first_i = ia; odd_low_i = od; rg_in_n = ln;
    #2;
  endtask

  task automatic next_cyc;
    @(negedge clk);
  endtask

  // Release held channel ch and pass the dead cycle
  task automatic release_ch(input int ch);
    logic [1:0] ln;
    ln = 2'b11; ln[ch] = 1'b0;
    drive(0, 0, 0, 0, ln);
    check("R5 hold before release", int'(hold_ack_o), 1);
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    check("R5 hold dropped", int'(hold_ack_o), 0);
    check("R6 dead cycle no grant", int'(rg_oe), 0);
    next_cyc;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    tstate_i = 3'd0; lock_i = 0; inta_first_i = 0; odd_low_i = 0; rg_in_n = 2'b11;
    repeat (3) @(negedge clk);
    #2;
    check("R1 reset oe", int'(rg_oe), 0);
    check("R1 reset out", int'(rg_out_n), 3);
    check("R1 reset hold", int'(hold_ack_o), 0);
    rst_n = 1'b1;
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    check("R1 after reset oe", int'(rg_oe), 0);
    next_cyc;

    // R2: lines held high across every T-state never grant
    for (int i = 0; i < 12; i++) begin
      drive(i % 6, 0, 0, 0, 2'b11);
      check("R2 idle line no grant", int'(rg_oe), 0);
      check("R2 idle line no hold", int'(hold_ack_o), 0);
      next_cyc;
    end

    // Sweep: grant-clock T-state x lock x inta x odd x late arrival
    for (int ts = 0; ts < 6; ts++) begin
      for (int q = 0; q < 16; q++) begin
        bit lk, ia, od, lt, exp_g;
        int ch;
        logic [1:0] ln;
        lk = q[0]; ia = q[1]; od = q[2]; lt = q[3];
        ch = (ts + q) % 2;
        ln = 2'b11; ln[ch] = 1'b0;
        drive(lt ? 3 : 2, 0, 0, 0, ln);
        check("R9 no grant in T2/T3", int'(rg_oe), 0);
        next_cyc;
        if (ts <= 1)      exp_g = !lk;
        else if (ts == 5) exp_g = !lk && !ia && !od && !lt;
        else              exp_g = 1'b0;
        drive(ts, lk, ia, od, 2'b11);
        check("R3 R7 R8 R9 grant decision", int'(rg_oe), exp_g ? (1 << ch) : 0);
        check("R3 line low with oe", int'(rg_out_n), exp_g ? (3 ^ (1 << ch)) : 3);
        next_cyc;
        if (!exp_g) begin
          drive(0, 0, 0, 0, 2'b11);
          check("R8 R9 pending kept", int'(rg_oe), 1 << ch);
          next_cyc;
        end
        drive(0, 0, 0, 0, 2'b11);
        check("R3 one-clock grant", int'(rg_oe), 0);
        check("R4 hold ack", int'(hold_ack_o), 1);
        check("R4 hold chan", int'(hold_chan_o), ch);
        next_cyc;
        release_ch(ch);
        drive(0, 0, 0, 0, 2'b11);
        check("R6 nothing left pending", int'(rg_oe), 0);
        next_cyc;
      end
    end

    // R10: simultaneous requests
    drive(0, 0, 0, 0, 2'b00);
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    check("R10 channel 0 wins", int'(rg_oe), 1);
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    check("R10 hold chan 0", int'(hold_chan_o), 0);
    next_cyc;
    release_ch(0);
    drive(0, 0, 0, 0, 2'b11);
    check("R10 channel 1 served after dead cycle", int'(rg_oe), 2);
    next_cyc;
    // R11: higher-priority pulse during channel 1 hold
    drive(0, 0, 0, 0, 2'b10);
    check("R11 hold by chan 1", int'(hold_chan_o), 1);
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    check("R11 non-holder pulse keeps hold", int'(hold_ack_o), 1);
    next_cyc;
    release_ch(1);
    drive(0, 0, 0, 0, 2'b11);
    check("R11 higher channel kept pending", int'(rg_oe), 1);
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    next_cyc;
    // R11: lower-priority pulse during channel 0 hold is dropped
    drive(0, 0, 0, 0, 2'b01);
    check("R11 hold by chan 0", int'(hold_ack_o), 1);
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    check("R11 lower pulse keeps hold", int'(hold_ack_o), 1);
    next_cyc;
    release_ch(0);
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 0, 0, 2'b11);
      check("R11 lower pulse never granted", int'(rg_oe), 0);
      next_cyc;
    end

    // R9: lock holds a request pending until it drops
    drive(0, 1, 0, 0, 2'b10);
    next_cyc;
    for (int i = 0; i < 3; i++) begin
      drive(i, 1, 0, 0, 2'b11);
      check("R9 lock blocks grant", int'(rg_oe), 0);
      next_cyc;
    end
    drive(1, 0, 0, 0, 2'b11);
    check("R9 grant after lock drops at T1", int'(rg_oe), 1);
    next_cyc;
    drive(0, 0, 0, 0, 2'b11);
    next_cyc;
    release_ch(0);

    finish_up();
  end
endmodule